// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a fixed set of maskable sources and from five non-maskable trap sources. It picks the one request the processor should take next. Every maskable source has a sticky pending flag, an enable and a 3-bit priority. A number of the low-indexed sources come from external pins. These are edge-detected, and each pin has its own polarity select. The other maskable sources set their flag whenever their condition input is high. Traps sit at fixed levels between 10 and 14, above every maskable level.

The controller holds the current processor level. When the processor takes an interrupt, the controller pushes that level onto a save stack and raises the level to that of the accepted request. When the processor returns, the controller pops the saved level. A request is offered only when its level is strictly greater than the current level, so handlers nest by priority. The controller never clears a flag. A status word records the level and vector of the last accepted request. While an oscillator-failure or address-error trap is pending, the processor is held stalled.

The offer logic is a two-state machine. In IDLE no request is presented. The IDLE→OFFER transition happens when the arbiter has a winner, whose vector and level are latched. The machine takes OFFER→IDLE on a take strobe, which accepts the latched request. It also takes OFFER→IDLE on a return strobe, or when the live winner no longer matches the latched one.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A maskable source with priority 0 is never offered, and `irq_lvl` is never 0 while `irq_req` is high.
- R2: A request is offered only when its level is strictly greater than `cpu_level`. A pending request at the same level as `cpu_level` waits.
- R3: Among eligible maskable requests the highest priority wins. On a tie, the lowest vector wins. Maskable source i has vector 5+i.
- R4: A source's flag sets when its condition occurs even while its enable is 0. The source is offered only while its enable is 1.
- R5: A take strobe while `irq_req` is high does three things: it pushes `cpu_level`, it loads `cpu_level` with `irq_lvl`, and it loads `status_word` with {level in the upper 4 bits, vector in the low bits}.
- R6: Flags clear only through their clear strobes. A set in the same cycle wins. After a return, a still-pending request is offered again.
- R7: Traps ignore enables and priorities. The trap vectors and levels are: oscillator failure vector 0 at level 14, address error vector 1 at 13, stack error vector 2 at 12, math error vector 3 at 11, and DMA conflict vector 4 at 10. `cpu_stall` is high while trap flag 0 or trap flag 1 is set.
- R8: The flag of pin source i sets on a rising edge of its input when its polarity bit is 0, and on a falling edge when the bit is 1. The opposite edge is ignored.
- R9: After reset the following are all 0: `cpu_level`, `irq_req`, `status_word`, every flag and `cpu_stall`.
- R10: A take with the save stack full sets the stack-error trap flag and saves nothing. A return with the stack empty restores level 0.
- R11: An offer is withdrawn when its winner is cleared or overtaken. The new winner is then offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_cond | input | N_SRC | Source conditions; the low N_PIN bits are pin levels |
| pin_fall_sel | input | N_PIN | Per-pin edge select: 1 falling, 0 rising |
| src_en | input | N_SRC | Per-source enable |
| src_prio | input | 3*N_SRC | Per-source priority, source i at bits [3i+2:3i] |
| src_flag_clr | input | N_SRC | Per-source flag clear strobe |
| trap_cond | input | 5 | Trap conditions, indexed by trap vector |
| trap_clr | input | 5 | Trap flag clear strobes |
| cpu_take | input | 1 | Processor accepts the offered request |
| cpu_ret | input | 1 | Processor returns from a handler |
| irq_req | output | 1 | A request is offered |
| irq_vec | output | VEC_W | Vector of the offered request |
| irq_lvl | output | 4 | Level of the offered request |
| cpu_level | output | 4 | Current processor level |
| cpu_stall | output | 1 | Hard trap pending, processor held |
| src_flags | output | N_SRC | Maskable pending flags |
| trap_flags | output | 5 | Trap pending flags |
| status_word | output | 4+VEC_W | Level and vector of the last accepted request |

## Verification
The bench builds the block with six maskable sources, two of them pins, and a save stack only four deep. Four nested maskable entries then fill the stack. A fifth entry, a trap, overflows it, so both the overflow path into the stack-error trap and the empty-stack return can be reached in a handful of cycles. Two pins are enough to exercise both polarities, including an edge that must be ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int TRAP_N = 5;
    localparam int LVL_W  = 4;
    localparam int PRIO_W = 3;

    localparam int TRAP_OSC   = 0;
    localparam int TRAP_ADDR  = 1;
    localparam int TRAP_STACK = 2;
    localparam int TRAP_MATH  = 3;
    localparam int TRAP_DMA   = 4;

    localparam int TRAP_TOP_LVL = 14;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } offer_state_e;
endpackage

// File: rtl/irqc_pin_edge.sv
module irqc_pin_edge #(
    parameter int N_PIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin_in,
    input  logic [N_PIN-1:0] fall_sel,
    output logic [N_PIN-1:0] edge_hit
);
    logic [N_PIN-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_in;
    end

    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
        always_comb begin
            if (fall_sel[g]) edge_hit[g] = prev_q[g] & ~pin_in[g];
            else             edge_hit[g] = pin_in[g] & ~prev_q[g];
        end

        // R8: a detected edge means the pin really moved since last sample
        assert_edge_moved_R8: assert property (@(posedge clk) disable iff (!rst_n)
            edge_hit[g] |-> (pin_in[g] != prev_q[g]));
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int VEC_W = 4
) (
    input  logic [TRAP_N-1:0]       trap_pend,
    input  logic [N_SRC-1:0]        src_pend,
    input  logic [N_SRC-1:0]        src_en,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic [LVL_W-1:0]        cur_lvl,
    output logic                    win_valid,
    output logic [VEC_W-1:0]        win_vec,
    output logic [LVL_W-1:0]        win_lvl
);
    logic              trap_found;
    logic [VEC_W-1:0]  trap_idx;
    logic              src_found;
    logic [VEC_W-1:0]  src_idx;
    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] cur_p;

    always_comb begin
        trap_found = 1'b0;
        trap_idx   = '0;
        for (int t = TRAP_N - 1; t >= 0; t--) begin
            if (trap_pend[t] && (LVL_W'(TRAP_TOP_LVL - t) > cur_lvl)) begin
                trap_found = 1'b1;
                trap_idx   = VEC_W'(t);
            end
        end
    end

    always_comb begin
        src_found = 1'b0;
        src_idx   = '0;
        best_p    = '0;
        cur_p     = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            cur_p = src_prio[i*PRIO_W +: PRIO_W];
            if (src_pend[i] && src_en[i] && ({1'b0, cur_p} > cur_lvl)
                && (!src_found || cur_p >= best_p)) begin
                src_found = 1'b1;
                best_p    = cur_p;
                src_idx   = VEC_W'(i);
            end
        end
    end

    always_comb begin
        win_valid = trap_found | src_found;
        win_vec   = '0;
        win_lvl   = '0;
        if (trap_found) begin
            win_vec = trap_idx;
            win_lvl = LVL_W'(TRAP_TOP_LVL) - LVL_W'(trap_idx);
        end else if (src_found) begin
            win_vec = src_idx + VEC_W'(TRAP_N);
            win_lvl = {1'b0, best_p};
        end
    end
endmodule

// File: rtl/irqc_lvl_stack.sv
module irqc_lvl_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top_out,
    output logic         overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] count_q;

    assign overflow = push && (count_q == CNT_W'(DEPTH));
    assign top_out  = (count_q == '0) ? '0 : mem[IDX_W'(count_q - CNT_W'(1))];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (push && !overflow) begin
            mem[IDX_W'(count_q)] <= din;
            count_q <= count_q + CNT_W'(1);
        end else if (pop && (count_q != '0)) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    assert_ovf_no_save_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (count_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int N_PIN       = 3,
    parameter int STACK_DEPTH = 8,
    localparam int VEC_W      = $clog2(TRAP_N + N_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         src_cond,
    input  logic [N_PIN-1:0]         pin_fall_sel,
    input  logic [N_SRC-1:0]         src_en,
    input  logic [N_SRC*PRIO_W-1:0]  src_prio,
    input  logic [N_SRC-1:0]         src_flag_clr,
    input  logic [TRAP_N-1:0]        trap_cond,
    input  logic [TRAP_N-1:0]        trap_clr,
    input  logic                     cpu_take,
    input  logic                     cpu_ret,
    output logic                     irq_req,
    output logic [VEC_W-1:0]         irq_vec,
    output logic [LVL_W-1:0]         irq_lvl,
    output logic [LVL_W-1:0]         cpu_level,
    output logic                     cpu_stall,
    output logic [N_SRC-1:0]         src_flags,
    output logic [TRAP_N-1:0]        trap_flags,
    output logic [LVL_W+VEC_W-1:0]   status_word
);
    offer_state_e     state_q, state_d;
    logic [VEC_W-1:0] off_vec_q;
    logic [LVL_W-1:0] off_lvl_q;

    logic [N_PIN-1:0]  pin_hit;
    logic [N_SRC-1:0]  src_set;
    logic [TRAP_N-1:0] trap_set;
    logic              win_valid;
    logic [VEC_W-1:0]  win_vec;
    logic [LVL_W-1:0]  win_lvl;
    logic              do_take, do_ret;
    logic [LVL_W-1:0]  saved_lvl;
    logic              stk_ovf;

    irqc_pin_edge #(.N_PIN(N_PIN)) u_pin_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (src_cond[N_PIN-1:0]),
        .fall_sel (pin_fall_sel),
        .edge_hit (pin_hit)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_set
        if (g < N_PIN) begin : g_pin_src
            assign src_set[g] = pin_hit[g];
        end else begin : g_cond_src
            assign src_set[g] = src_cond[g];
        end
    end

    always_comb begin
        trap_set = trap_cond;
        trap_set[TRAP_STACK] = trap_cond[TRAP_STACK] | stk_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_flags  <= '0;
            trap_flags <= '0;
        end else begin
            src_flags  <= (src_flags & ~src_flag_clr) | src_set;
            trap_flags <= (trap_flags & ~trap_clr) | trap_set;
        end
    end

    irqc_pick #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_pick (
        .trap_pend (trap_flags),
        .src_pend  (src_flags),
        .src_en    (src_en),
        .src_prio  (src_prio),
        .cur_lvl   (cpu_level),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .win_lvl   (win_lvl)
    );

    assign do_take = (state_q == ST_OFFER) && cpu_take;
    assign do_ret  = cpu_ret && !do_take;

    irqc_lvl_stack #(.DEPTH(STACK_DEPTH), .W(LVL_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_take),
        .pop      (do_ret),
        .din      (cpu_level),
        .top_out  (saved_lvl),
        .overflow (stk_ovf)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_valid) state_d = ST_OFFER;
            end
            ST_OFFER: begin
                if (cpu_take || cpu_ret || !win_valid
                    || (win_vec != off_vec_q) || (win_lvl != off_lvl_q))
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers driven by the machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_vec_q   <= '0;
            off_lvl_q   <= '0;
            cpu_level   <= '0;
            status_word <= '0;
        end else begin
            if ((state_q == ST_IDLE) && win_valid) begin
                off_vec_q <= win_vec;
                off_lvl_q <= win_lvl;
            end
            if (do_take) begin
                cpu_level   <= off_lvl_q;
                status_word <= {off_lvl_q, off_vec_q};
            end else if (do_ret) begin
                cpu_level <= saved_lvl;
            end
        end
    end

    // outputs
    always_comb begin
        irq_req   = (state_q == ST_OFFER);
        irq_vec   = off_vec_q;
        irq_lvl   = off_lvl_q;
        cpu_stall = trap_flags[TRAP_OSC] | trap_flags[TRAP_ADDR];
    end

    assert_req_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl != '0));

    assert_req_above_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > cpu_level));

    assert_take_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cpu_take) |=> (cpu_level == $past(irq_lvl)));

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_flags & $past(src_flags & ~src_flag_clr))
                  == $past(src_flags & ~src_flag_clr)));

    assert_hard_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trap_cond[TRAP_ADDR]) |-> cpu_stall);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    localparam int NS = 6;
    localparam int NP = 2;
    localparam int SD = 4;
    localparam int VW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   src_cond = '0;
    logic [NP-1:0]   pin_fall_sel = '0;
    logic [NS-1:0]   src_en = '0;
    logic [NS*3-1:0] src_prio = '0;
    logic [NS-1:0]   src_flag_clr = '0;
    logic [4:0]      trap_cond = '0;
    logic [4:0]      trap_clr = '0;
    logic            cpu_take = 1'b0;
    logic            cpu_ret = 1'b0;
    logic            irq_req;
    logic [VW-1:0]   irq_vec;
    logic [3:0]      irq_lvl;
    logic [3:0]      cpu_level;
    logic            cpu_stall;
    logic [NS-1:0]   src_flags;
    logic [4:0]      trap_flags;
    logic [4+VW-1:0] status_word;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    prio_irq_ctrl #(.N_SRC(NS), .N_PIN(NP), .STACK_DEPTH(SD)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_cond(src_cond), .pin_fall_sel(pin_fall_sel),
        .src_en(src_en), .src_prio(src_prio), .src_flag_clr(src_flag_clr),
        .trap_cond(trap_cond), .trap_clr(trap_clr), .cpu_take(cpu_take),
        .cpu_ret(cpu_ret), .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .cpu_level(cpu_level), .cpu_stall(cpu_stall), .src_flags(src_flags),
        .trap_flags(trap_flags), .status_word(status_word)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_src(input int i);
        src_cond[i] = 1'b1;
        step();
        src_cond[i] = 1'b0;
    endtask

    task automatic pulse_trap(input int t);
        trap_cond[t] = 1'b1;
        step();
        trap_cond[t] = 1'b0;
    endtask

    task automatic do_take();
        cpu_take = 1'b1;
        step();
        cpu_take = 1'b0;
    endtask

    task automatic do_ret();
        cpu_ret = 1'b1;
        step();
        cpu_ret = 1'b0;
    endtask

    task automatic wait_req(input int max_cyc);
        for (int k = 0; k < max_cyc; k++) begin
            if (irq_req) break;
            step();
        end
    endtask

    task automatic set_prio(input int i, input int p);
        src_prio[i*3 +: 3] = 3'(p);
    endtask

    task automatic cleanup();
        src_en = '0;
        src_prio = '0;
        src_flag_clr = '1;
        trap_clr = '1;
        step();
        src_flag_clr = '0;
        trap_clr = '0;
        for (int k = 0; k < 16; k++) begin
            if (cpu_level == 0) break;
            do_ret();
        end
        step();
        step();
    endtask

    task automatic t_reset();
        chk("R9 irq_req", irq_req, 0);
        chk("R9 cpu_level", cpu_level, 0);
        chk("R9 status", status_word, 0);
        chk("R9 flags", {trap_flags, src_flags}, 0);
        chk("R9 stall", cpu_stall, 0);
    endtask

    task automatic t_latch_take_return();
        set_prio(3, 5);
        pulse_src(3);
        step(); step(); step();
        chk("R4 flag set while disabled", src_flags[3], 1);
        chk("R4 disabled not offered", irq_req, 0);
        src_en[3] = 1'b1;
        wait_req(6);
        chk("R4 enabled offered", irq_req, 1);
        chk("R4 vector", irq_vec, 8);
        do_take();
        chk("R5 level raised", cpu_level, 5);
        chk("R5 status", status_word, (5 << VW) | 8);
        step(); step();
        chk("R2 same level not reoffered", irq_req, 0);
        set_prio(4, 5);
        src_en[4] = 1'b1;
        pulse_src(4);
        step(); step(); step();
        chk("R2 equal priority waits", irq_req, 0);
        set_prio(4, 6);
        wait_req(6);
        chk("R2 higher preempts vec", irq_vec, 9);
        do_take();
        chk("R5 nested level", cpu_level, 6);
        do_ret();
        chk("R5 return restores", cpu_level, 5);
        src_flag_clr[4] = 1'b1;
        step();
        src_flag_clr[4] = 1'b0;
        chk("R6 clear strobe clears", src_flags[4], 0);
        do_ret();
        chk("R6 back to level 0", cpu_level, 0);
        wait_req(6);
        chk("R6 pending reoffered", irq_req, 1);
        chk("R6 reoffer vec", irq_vec, 8);
        cleanup();
    endtask

    task automatic t_tie_and_prio0();
        set_prio(2, 3); set_prio(4, 3); set_prio(5, 4); set_prio(3, 0);
        src_en = 6'b111100;
        src_cond[2] = 1'b1; src_cond[3] = 1'b1; src_cond[4] = 1'b1; src_cond[5] = 1'b1;
        step();
        src_cond = '0;
        wait_req(6);
        chk("R3 highest wins vec", irq_vec, 10);
        chk("R3 highest wins lvl", irq_lvl, 4);
        src_flag_clr[5] = 1'b1;
        step();
        src_flag_clr[5] = 1'b0;
        step();
        chk("R11 offer withdrawn", irq_req, 0);
        wait_req(6);
        chk("R3 tie lowest vector", irq_vec, 7);
        chk("R11 new winner level", irq_lvl, 3);
        src_flag_clr = 6'b010100;
        step();
        src_flag_clr = '0;
        step(); step(); step();
        chk("R1 prio0 flag pending", src_flags[3], 1);
        chk("R1 prio0 not offered", irq_req, 0);
        cleanup();
    endtask

    task automatic t_pins();
        pin_fall_sel = 2'b10;
        src_cond[0] = 1'b1;
        step();
        chk("R8 rising edge sets", src_flags[0], 1);
        src_cond[1] = 1'b1;
        step();
        chk("R8 rising ignored on falling pin", src_flags[1], 0);
        src_cond[1] = 1'b0;
        src_cond[0] = 1'b0;
        step();
        chk("R8 falling edge sets", src_flags[1], 1);
        src_flag_clr[0] = 1'b1;
        step();
        src_flag_clr[0] = 1'b0;
        chk("R8 falling ignored on rising pin", src_flags[0], 0);
        cleanup();
    endtask

    task automatic t_traps();
        pulse_trap(3);
        wait_req(6);
        chk("R7 math trap vec", irq_vec, 3);
        chk("R7 math trap lvl", irq_lvl, 11);
        chk("R7 soft trap no stall", cpu_stall, 0);
        do_take();
        chk("R7 status trap", status_word, (11 << VW) | 3);
        pulse_trap(1);
        chk("R7 hard trap stall", cpu_stall, 1);
        wait_req(6);
        chk("R7 addr trap vec", irq_vec, 1);
        chk("R7 addr trap lvl", irq_lvl, 13);
        cleanup();
        chk("R7 stall drops on clear", cpu_stall, 0);
    endtask

    task automatic t_stack();
        for (int i = 2; i < 6; i++) begin
            set_prio(i, i - 1);
            src_en[i] = 1'b1;
            pulse_src(i);
            wait_req(6);
            do_take();
        end
        chk("R10 nested four deep", cpu_level, 4);
        pulse_trap(4);
        wait_req(6);
        chk("R10 dma trap vec", irq_vec, 4);
        do_take();
        chk("R10 overflow sets stack trap", trap_flags[2], 1);
        chk("R10 level after overflow take", cpu_level, 10);
        wait_req(6);
        chk("R10 stack trap offered", irq_vec, 2);
        src_en = '0;
        src_flag_clr = '1;
        trap_clr = '1;
        step();
        src_flag_clr = '0;
        trap_clr = '0;
        do_ret();
        chk("R10 return gets last saved", cpu_level, 3);
        do_ret(); do_ret(); do_ret();
        chk("R10 bottom of stack", cpu_level, 0);
        set_prio(2, 0);
        do_ret();
        chk("R10 empty return level 0", cpu_level, 0);
        cleanup();
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_latch_take_return();
        t_tie_and_prio0();
        t_pins();
        t_traps();
        t_stack();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule